// File: doc/BRIEF.md
# Cipher Job Sequencer

This block runs a multi-block cipher job between two block-addressed buffers: a plaintext buffer and a ciphertext buffer, each `DEPTH` entries of 64 bits, held outside the block. Software programs, through a small word-addressed register port, the starting entry in each buffer and the block count. It may also load a 64-bit chaining value. It then writes a mode word whose start bit launches the job. The sequencer walks the blocks one at a time. For each block it reads the source entry and passes a 64-bit word to an external single-block cipher engine over a request/acknowledge handshake. It then writes the engine result, after any chaining, to the destination entry.

Encryption moves data from the plaintext buffer to the ciphertext buffer, and decryption moves it the other way. In chained mode the block applies the usual cipher-block-chaining combination and updates the chaining registers as it goes. When the job ends, those registers hold the value needed to continue the stream in a later job. Completion is flagged in status, together with a pending interrupt that can be masked and cleared. A start whose block range would run past the end of either buffer is refused and recorded as a length error. A separate request fills both buffers with zeros.

The controller is one state machine with the states IDLE, READ (issue the source read), LOAD (capture the read data), CIPHER (hold the engine request until acknowledge), WRITE (store the result) and WIPE (zero fill). Its transitions are:
- IDLE→READ on an accepted start.
- IDLE→WIPE on a zeroize request.
- READ→LOAD and LOAD→CIPHER unconditionally.
- CIPHER→WRITE on acknowledge.
- WRITE→READ when blocks remain, and WRITE→IDLE after the last block.
- WIPE→IDLE after the final entry of the ciphertext buffer.

Top module: `cipher_job_ctrl`

## Requirements
- R1: Register indices: 0 plaintext start entry, 1 ciphertext start entry, 2 block count minus one, 3 mode, 4 status, 5 error, 6 interrupt control, 7 chaining value bits 31:0, 8 chaining value bits 63:32. After reset every register reads zero. While busy, writes to indices 0, 1, 2, 3, 7 and 8 are ignored.
- R2: A write to index 3 with bit 2 set starts a job when the range check passes; bit 1 selects chained mode and bit 0 selects decrypt. Status bit 0 (busy) and bit 2 (ciphering) read 1 from the cycle after that write until the last block has been written.
- R3: A count register value of N processes exactly N+1 blocks, including N = 0.
- R4: Block i of an encrypt job is read from plaintext entry pstart+i and written to ciphertext entry cstart+i. A decrypt job reads ciphertext entry cstart+i and writes plaintext entry pstart+i. The buffer select is 0 for plaintext and 1 for ciphertext, and start values are entry indices, not bytes.
- R5: Without chaining, the engine receives the source block unchanged and its result is stored unchanged.
- R6: In chained encrypt, the engine receives the source block XOR the chaining value, and the engine result becomes the new chaining value.
- R7: In chained decrypt, the stored block is the engine result XOR the chaining value, and the source block becomes the new chaining value.
- R8: After a chained job, indices 7 and 8 read the final chaining value.
- R9: Status bit 10 (done) and bit 8 (pending) become 1 in the same cycle that busy falls. The interrupt output equals pending AND NOT mask, where the mask is bit 0 of index 6. Writing index 6 with bit 1 set clears pending and done.
- R10: If start + count + 1 exceeds DEPTH for either buffer, a start write makes no buffer or engine access. It sets status bit 12 and error bit 0 instead. Writing zero to index 5 clears the error. A range that ends exactly at the last entry is accepted.
- R11: The engine request stays high with stable data until acknowledge, and exactly one request is acknowledged per block.
- R12: Writing index 6 with bit 2 set while idle writes zero to every entry of both buffers. Meanwhile status bits 0 and 1 read 1 and bit 2 reads 0, and the fill sets neither done nor pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mem_en | output | 1 | Buffer access enable |
| mem_we | output | 1 | Buffer write (1) or read (0) |
| mem_sel | output | 1 | Buffer select: 0 plaintext, 1 ciphertext |
| mem_addr | output | AW | Buffer entry index |
| mem_wdata | output | 64 | Buffer write data |
| mem_rdata | input | 64 | Buffer read data, valid the cycle after a read |
| eng_req | output | 1 | Engine request, held until acknowledge |
| eng_decrypt | output | 1 | Engine direction for this job |
| eng_din | output | 64 | Engine input block |
| eng_ack | input | 1 | Engine acknowledge with result |
| eng_dout | input | 64 | Engine result, valid with eng_ack |
| irq | output | 1 | Interrupt request |

## Verification
A start write becomes busy one edge later. Each block then takes one read cycle, one capture cycle, the engine wait including the acknowledge cycle, and one write cycle. Done and pending appear on the first sample where busy is low. The bench drives on falling edges and compares each buffer write at the falling edge of the cycle in which it is presented, against a queue built from its own model of the job. It polls status every cycle, so it catches the exact cycle busy falls and can check done and pending in that same sample. Refused starts and ignored writes are checked after a fixed number of idle cycles, through the status, error, engine-acknowledge count and register read-back.

// File: rtl/cjc_pkg.sv
package cjc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_LOAD,
        ST_CIPHER,
        ST_WRITE,
        ST_WIPE
    } cjc_state_e;

    localparam logic [3:0] RA_PSTART   = 4'd0;
    localparam logic [3:0] RA_CSTART   = 4'd1;
    localparam logic [3:0] RA_COUNT    = 4'd2;
    localparam logic [3:0] RA_MODE     = 4'd3;
    localparam logic [3:0] RA_STATUS   = 4'd4;
    localparam logic [3:0] RA_ERROR    = 4'd5;
    localparam logic [3:0] RA_IRQCTL   = 4'd6;
    localparam logic [3:0] RA_CHAIN_LO = 4'd7;
    localparam logic [3:0] RA_CHAIN_HI = 4'd8;

    localparam int MB_DEC = 0;
    localparam int MB_CBC = 1;
    localparam int MB_GO  = 2;

    localparam int SB_BUSY   = 0;
    localparam int SB_WIPING = 1;
    localparam int SB_CIPHER = 2;
    localparam int SB_PEND   = 8;
    localparam int SB_DONE   = 10;
    localparam int SB_LENERR = 12;

    localparam int IB_MASK  = 0;
    localparam int IB_CLEAR = 1;
    localparam int IB_WIPE  = 2;

endpackage

// File: rtl/cjc_regs.sv
module cjc_regs
    import cjc_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [3:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          busy,
    input  logic          wiping,
    input  logic          job_done,
    input  logic          chain_we,
    input  logic [63:0]   chain_nxt,
    output logic [AW-1:0] pstart,
    output logic [AW-1:0] cstart,
    output logic [AW-1:0] blk_cnt,
    output logic [63:0]   chain,
    output logic          go,
    output logic          go_cbc,
    output logic          go_dec,
    output logic          wipe_go,
    output logic          sts_done,
    output logic          sts_pend,
    output logic          sts_lenerr,
    output logic          irq
);

    localparam int EW = AW + 2;
    localparam logic [EW-1:0] DEPTH_W = EW'(DEPTH);

    logic [1:0]    mode_q;
    logic          mask_q;
    logic          wr_cfg;
    logic          start_wr;
    logic          range_bad;
    logic          clr_wr;
    logic [EW-1:0] p_end;
    logic [EW-1:0] c_end;

    assign wr_cfg   = reg_wr && !busy;
    assign start_wr = wr_cfg && (reg_addr == RA_MODE) && reg_wdata[MB_GO];
    assign clr_wr   = reg_wr && (reg_addr == RA_IRQCTL) && reg_wdata[IB_CLEAR];

    assign p_end = EW'(pstart) + EW'(blk_cnt) + EW'(1);
    assign c_end = EW'(cstart) + EW'(blk_cnt) + EW'(1);
    assign range_bad = (p_end > DEPTH_W) || (c_end > DEPTH_W);

    assign go      = start_wr && !range_bad;
    assign go_cbc  = reg_wdata[MB_CBC];
    assign go_dec  = reg_wdata[MB_DEC];
    assign wipe_go = wr_cfg && (reg_addr == RA_IRQCTL) && reg_wdata[IB_WIPE];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pstart  <= '0;
            cstart  <= '0;
            blk_cnt <= '0;
            mode_q  <= '0;
            chain   <= '0;
        end else begin
            if (wr_cfg && reg_addr == RA_PSTART) pstart  <= reg_wdata[AW-1:0];
            if (wr_cfg && reg_addr == RA_CSTART) cstart  <= reg_wdata[AW-1:0];
            if (wr_cfg && reg_addr == RA_COUNT)  blk_cnt <= reg_wdata[AW-1:0];
            if (wr_cfg && reg_addr == RA_MODE)   mode_q  <= reg_wdata[1:0];
            if (chain_we) begin
                chain <= chain_nxt;
            end else if (wr_cfg && reg_addr == RA_CHAIN_LO) begin
                chain[31:0] <= reg_wdata;
            end else if (wr_cfg && reg_addr == RA_CHAIN_HI) begin
                chain[63:32] <= reg_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q     <= 1'b0;
            sts_done   <= 1'b0;
            sts_pend   <= 1'b0;
            sts_lenerr <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == RA_IRQCTL) mask_q <= reg_wdata[IB_MASK];
            if (job_done) begin
                sts_done <= 1'b1;
                sts_pend <= 1'b1;
            end else if (go || clr_wr) begin
                sts_done <= 1'b0;
                sts_pend <= 1'b0;
            end
            if (start_wr && range_bad) begin
                sts_lenerr <= 1'b1;
            end else if (reg_wr && reg_addr == RA_ERROR && reg_wdata == '0) begin
                sts_lenerr <= 1'b0;
            end
        end
    end

    assign irq = sts_pend && !mask_q;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_PSTART:   reg_rdata = 32'(pstart);
            RA_CSTART:   reg_rdata = 32'(cstart);
            RA_COUNT:    reg_rdata = 32'(blk_cnt);
            RA_MODE:     reg_rdata = 32'(mode_q);
            RA_STATUS: begin
                reg_rdata[SB_BUSY]   = busy;
                reg_rdata[SB_WIPING] = wiping;
                reg_rdata[SB_CIPHER] = busy && !wiping;
                reg_rdata[SB_PEND]   = sts_pend;
                reg_rdata[SB_DONE]   = sts_done;
                reg_rdata[SB_LENERR] = sts_lenerr;
            end
            RA_ERROR:    reg_rdata = 32'(sts_lenerr);
            RA_IRQCTL:   reg_rdata = 32'(mask_q);
            RA_CHAIN_LO: reg_rdata = chain[31:0];
            RA_CHAIN_HI: reg_rdata = chain[63:32];
            default:     reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cjc_seq.sv
module cjc_seq
    import cjc_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          go_cbc,
    input  logic          go_dec,
    input  logic          wipe_go,
    input  logic [AW-1:0] pstart,
    input  logic [AW-1:0] cstart,
    input  logic [AW-1:0] blk_cnt,
    input  logic [63:0]   chain,
    output logic          mem_en,
    output logic          mem_we,
    output logic          mem_sel,
    output logic [AW-1:0] mem_addr,
    output logic [63:0]   mem_wdata,
    input  logic [63:0]   mem_rdata,
    output logic          eng_req,
    output logic          eng_decrypt,
    output logic [63:0]   eng_din,
    input  logic          eng_ack,
    input  logic [63:0]   eng_dout,
    output logic          busy,
    output logic          wiping,
    output logic          job_done,
    output logic          chain_we,
    output logic [63:0]   chain_nxt
);

    localparam logic [AW-1:0] LAST_ENTRY = AW'(DEPTH - 1);

    cjc_state_e    state;
    cjc_state_e    nxt;
    logic [AW-1:0] idx;
    logic [AW-1:0] wipe_addr;
    logic          wipe_sel;
    logic          cbc_q;
    logic          dec_q;
    logic [63:0]   src_q;
    logic [63:0]   res_q;
    logic          last_blk;
    logic          wipe_end;
    logic [AW-1:0] src_addr;
    logic [AW-1:0] dst_addr;

    assign last_blk = (idx == blk_cnt);
    assign wipe_end = wipe_sel && (wipe_addr == LAST_ENTRY);
    assign src_addr = (dec_q ? cstart : pstart) + idx;
    assign dst_addr = (dec_q ? pstart : cstart) + idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (go)           nxt = ST_READ;
                else if (wipe_go) nxt = ST_WIPE;
            end
            ST_READ:   nxt = ST_LOAD;
            ST_LOAD:   nxt = ST_CIPHER;
            ST_CIPHER: if (eng_ack) nxt = ST_WRITE;
            ST_WRITE:  nxt = last_blk ? ST_IDLE : ST_READ;
            ST_WIPE:   if (wipe_end) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_sel   = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        eng_req   = 1'b0;
        job_done  = 1'b0;
        unique case (state)
            ST_READ: begin
                mem_en   = 1'b1;
                mem_sel  = dec_q;
                mem_addr = src_addr;
            end
            ST_CIPHER: eng_req = 1'b1;
            ST_WRITE: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_sel   = !dec_q;
                mem_addr  = dst_addr;
                mem_wdata = res_q;
                job_done  = last_blk;
            end
            ST_WIPE: begin
                mem_en   = 1'b1;
                mem_we   = 1'b1;
                mem_sel  = wipe_sel;
                mem_addr = wipe_addr;
            end
            default: ;
        endcase
    end

    assign busy        = (state != ST_IDLE);
    assign wiping      = (state == ST_WIPE);
    assign eng_decrypt = dec_q;
    assign eng_din     = (cbc_q && !dec_q) ? (src_q ^ chain) : src_q;
    assign chain_we    = cbc_q && (state == ST_CIPHER) && eng_ack;
    assign chain_nxt   = dec_q ? src_q : eng_dout;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx       <= '0;
            wipe_addr <= '0;
            wipe_sel  <= 1'b0;
            cbc_q     <= 1'b0;
            dec_q     <= 1'b0;
            src_q     <= '0;
            res_q     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    idx       <= '0;
                    wipe_addr <= '0;
                    wipe_sel  <= 1'b0;
                    if (go) begin
                        cbc_q <= go_cbc;
                        dec_q <= go_dec;
                    end
                end
                ST_LOAD: src_q <= mem_rdata;
                ST_CIPHER: begin
                    if (eng_ack) res_q <= (cbc_q && dec_q) ? (eng_dout ^ chain) : eng_dout;
                end
                ST_WRITE: idx <= idx + AW'(1);
                ST_WIPE: begin
                    if (wipe_addr == LAST_ENTRY) begin
                        wipe_addr <= '0;
                        wipe_sel  <= 1'b1;
                    end else begin
                        wipe_addr <= wipe_addr + AW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cipher_job_ctrl.sv
module cipher_job_ctrl
    import cjc_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [3:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_en,
    output logic          mem_we,
    output logic          mem_sel,
    output logic [AW-1:0] mem_addr,
    output logic [63:0]   mem_wdata,
    input  logic [63:0]   mem_rdata,
    output logic          eng_req,
    output logic          eng_decrypt,
    output logic [63:0]   eng_din,
    input  logic          eng_ack,
    input  logic [63:0]   eng_dout,
    output logic          irq
);

    logic          busy;
    logic          wiping;
    logic          job_done;
    logic          chain_we;
    logic [63:0]   chain_nxt;
    logic [63:0]   chain;
    logic [AW-1:0] pstart;
    logic [AW-1:0] cstart;
    logic [AW-1:0] blk_cnt;
    logic          go;
    logic          go_cbc;
    logic          go_dec;
    logic          wipe_go;
    logic          sts_done;
    logic          sts_pend;
    logic          sts_lenerr;

    cjc_regs #(.DEPTH(DEPTH), .AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy       (busy),
        .wiping     (wiping),
        .job_done   (job_done),
        .chain_we   (chain_we),
        .chain_nxt  (chain_nxt),
        .pstart     (pstart),
        .cstart     (cstart),
        .blk_cnt    (blk_cnt),
        .chain      (chain),
        .go         (go),
        .go_cbc     (go_cbc),
        .go_dec     (go_dec),
        .wipe_go    (wipe_go),
        .sts_done   (sts_done),
        .sts_pend   (sts_pend),
        .sts_lenerr (sts_lenerr),
        .irq        (irq)
    );

    cjc_seq #(.DEPTH(DEPTH), .AW(AW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .go          (go),
        .go_cbc      (go_cbc),
        .go_dec      (go_dec),
        .wipe_go     (wipe_go),
        .pstart      (pstart),
        .cstart      (cstart),
        .blk_cnt     (blk_cnt),
        .chain       (chain),
        .mem_en      (mem_en),
        .mem_we      (mem_we),
        .mem_sel     (mem_sel),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .eng_req     (eng_req),
        .eng_decrypt (eng_decrypt),
        .eng_din     (eng_din),
        .eng_ack     (eng_ack),
        .eng_dout    (eng_dout),
        .busy        (busy),
        .wiping      (wiping),
        .job_done    (job_done),
        .chain_we    (chain_we),
        .chain_nxt   (chain_nxt)
    );

endmodule

// File: rtl/cjc_checker.sv
module cjc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        wiping,
    input logic        sts_done,
    input logic        sts_pend,
    input logic        sts_lenerr,
    input logic        irq,
    input logic        eng_req,
    input logic        eng_ack,
    input logic [63:0] eng_din,
    input logic        mem_en,
    input logic        mem_we,
    input logic [63:0] mem_wdata
);

    assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_ack) |=> (eng_req && $stable(eng_din)));

    assert_access_only_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> busy);

    assert_done_with_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_done) |-> ($rose(sts_pend) && !busy));

    assert_irq_needs_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> sts_pend);

    assert_refused_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_lenerr) |-> !busy);

    assert_wipe_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wiping && mem_en) |-> (mem_we && mem_wdata == '0));

    assert_wipe_no_engine_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wiping |-> !eng_req);

endmodule

bind cipher_job_ctrl cjc_checker i_cjc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .wiping     (wiping),
    .sts_done   (sts_done),
    .sts_pend   (sts_pend),
    .sts_lenerr (sts_lenerr),
    .irq        (irq),
    .eng_req    (eng_req),
    .eng_ack    (eng_ack),
    .eng_din    (eng_din),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata)
);

// File: tb/test_cipher_job_ctrl.sv
module test_cipher_job_ctrl;

    localparam int DEPTH = 32;
    localparam int AW    = $clog2(DEPTH);
    localparam logic [63:0] KEY = 64'h0F1E_2D3C_4B5A_6978;

    typedef struct packed {
        logic          sel;
        logic [AW-1:0] addr;
        logic [63:0]   data;
    } wr_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          mem_en, mem_we, mem_sel;
    logic [AW-1:0] mem_addr;
    logic [63:0]   mem_wdata;
    logic [63:0]   mem_rdata = '0;
    logic          eng_req, eng_decrypt;
    logic [63:0]   eng_din;
    logic          eng_ack = 1'b0;
    logic [63:0]   eng_dout = '0;
    logic          irq;

    logic [63:0] pt_mem [DEPTH];
    logic [63:0] ct_mem [DEPTH];
    logic [63:0] pt_orig [DEPTH];
    wr_item_t    exp_q [$];
    int          checks = 0;
    int          fails = 0;
    int          acks = 0;
    int          dly = 0;
    int          cyc = 0;
    logic        wipe_phase = 1'b0;
    logic        tb_mask = 1'b0;
    logic [63:0] tb_chain = '0;
    string       cur_tag = "R4";

    always #4 clk = ~clk;

    cipher_job_ctrl #(.DEPTH(DEPTH)) i_cipher_job_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_en(mem_en),
        .mem_we(mem_we), .mem_sel(mem_sel), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .eng_req(eng_req),
        .eng_decrypt(eng_decrypt), .eng_din(eng_din), .eng_ack(eng_ack),
        .eng_dout(eng_dout), .irq(irq)
    );

    function automatic logic [63:0] engf(input logic [63:0] x, input logic d);
        logic [63:0] y;
        y = d ? (x ^ KEY) : x;
        y = {y[31:0], y[63:32]};
        return d ? y : (y ^ KEY);
    endfunction

    // buffer model, one-cycle read
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                if (mem_sel) ct_mem[mem_addr] <= mem_wdata;
                else         pt_mem[mem_addr] <= mem_wdata;
            end else begin
                mem_rdata <= mem_sel ? ct_mem[mem_addr] : pt_mem[mem_addr];
            end
        end
    end

    // engine model with varying latency
    always @(posedge clk) begin
        if (!rst_n) begin
            eng_ack <= 1'b0;
            dly     <= 0;
        end else if (eng_ack) begin
            eng_ack <= 1'b0;
        end else if (eng_req) begin
            if (dly >= (acks % 3)) begin
                eng_ack  <= 1'b1;
                eng_dout <= engf(eng_din, eng_decrypt);
                dly      <= 0;
                acks     <= acks + 1;
            end else begin
                dly <= dly + 1;
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: compare each buffer write against the scoreboard
    always @(negedge clk) begin
        if (rst_n && mem_en && mem_we && !wipe_phase) begin
            if (exp_q.size() == 0) begin
                check(cur_tag, {1'b1, mem_sel, 3'b0, 59'(mem_addr)}, 64'h0);
            end else begin
                wr_item_t e;
                e = exp_q.pop_front();
                check(cur_tag, {63'(mem_sel), 1'b0} | {mem_wdata ^ e.data},
                      {63'(e.sel), 1'b0});
                check("R4", 64'(mem_addr), 64'(e.addr));
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc == 150000) begin
                checks++;
                fails++;
                $display("FAIL watchdog actual=hung expected=finished");
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle(output logic [31:0] st);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            rd(4'd4, st);
            if (!st[0]) break;
        end
    endtask

    task automatic set_chain(input logic [63:0] v);
        wr(4'd7, v[31:0]);
        wr(4'd8, v[63:32]);
        tb_chain = v;
    endtask

    task automatic run_job(input string tag, input int pb, input int cb, input int cnt,
                           input logic cbc, input logic dec, input logic poke);
        logic [31:0] st;
        logic [31:0] v;
        int          a0;
        wr(4'd0, 32'(pb));
        wr(4'd1, 32'(cb));
        wr(4'd2, 32'(cnt));
        for (int i = 0; i <= cnt; i++) begin
            logic [63:0] src, r, o;
            wr_item_t    it;
            src = dec ? ct_mem[cb + i] : pt_mem[pb + i];
            if (!dec) begin
                r = engf(cbc ? (src ^ tb_chain) : src, 1'b0);
                o = r;
                if (cbc) tb_chain = r;
            end else begin
                r = engf(src, 1'b1);
                o = cbc ? (r ^ tb_chain) : r;
                if (cbc) tb_chain = src;
            end
            it.sel  = !dec;
            it.addr = AW'(dec ? pb + i : cb + i);
            it.data = o;
            exp_q.push_back(it);
        end
        cur_tag = tag;
        a0 = acks;
        wr(4'd3, {29'd0, 1'b1, cbc, dec});
        rd(4'd4, st);
        check("R2", 64'({st[10], st[2], st[0]}), 64'b011);
        if (poke) begin
            wr(4'd0, 32'd31);
            wr(4'd7, 32'h5555_AAAA);
        end
        wait_idle(st);
        check("R9", 64'({st[10], st[8], st[0]}), 64'b110);
        check("R9", 64'(irq), 64'(!tb_mask));
        check("R3", 64'(exp_q.size()), 64'd0);
        check("R11", 64'(acks - a0), 64'(cnt + 1));
        if (cbc) begin
            rd(4'd7, v);
            check("R8", 64'(v), 64'(tb_chain[31:0]));
            rd(4'd8, v);
            check("R8", 64'(v), 64'(tb_chain[63:32]));
        end
        if (poke) begin
            rd(4'd0, v);
            check("R1", 64'(v), 64'(pb));
        end
    endtask

    initial begin
        logic [31:0] st;
        logic [31:0] v;
        int          a0;
        int          bad;
        for (int i = 0; i < DEPTH; i++) begin
            pt_mem[i]  = 64'hDEAD_BEEF_0000_0000 ^ (64'(i) * 64'h0101_0103_0107_0109);
            pt_orig[i] = pt_mem[i];
            ct_mem[i]  = 64'h3C3C_0000_0000_0000 | 64'(i);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset values
        rd(4'd4, st); check("R1", 64'(st), 64'd0);
        rd(4'd7, v);  check("R1", 64'(v), 64'd0);
        rd(4'd2, v);  check("R1", 64'(v), 64'd0);
        check("R9", 64'(irq), 64'd0);

        // plain encrypt, four blocks
        run_job("R4", 2, 5, 3, 1'b0, 1'b0, 1'b0);
        wr(4'd6, 32'h2);
        // single block
        run_job("R3", 10, 0, 0, 1'b0, 1'b0, 1'b0);
        // plain decrypt
        run_job("R5", 26, 5, 3, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 4; i++) check("R5", pt_mem[26 + i], pt_orig[2 + i]);

        // chained encrypt then chained decrypt, with ignored writes while busy
        set_chain(64'h0123_4567_89AB_CDEF);
        run_job("R6", 0, 16, 4, 1'b1, 1'b0, 1'b1);
        set_chain(64'h0123_4567_89AB_CDEF);
        run_job("R7", 20, 16, 4, 1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 5; i++) check("R7", pt_mem[20 + i], pt_orig[i]);

        // masked interrupt, then clear
        wr(4'd6, 32'h1);
        tb_mask = 1'b1;
        run_job("R9", 12, 8, 2, 1'b0, 1'b0, 1'b0);
        wr(4'd6, 32'h3);
        rd(4'd4, st);
        check("R9", 64'({st[10], st[8]}), 64'd0);
        wr(4'd6, 32'h0);
        tb_mask = 1'b0;

        // range errors
        a0 = acks;
        wr(4'd0, 32'd30); wr(4'd1, 32'd0); wr(4'd2, 32'd2);
        wr(4'd3, 32'h4);
        rd(4'd4, st);
        check("R10", 64'({st[12], st[0]}), 64'b10);
        repeat (8) @(negedge clk);
        rd(4'd5, v);
        check("R10", 64'(v), 64'd1);
        check("R10", 64'(acks - a0), 64'd0);
        wr(4'd5, 32'd0);
        rd(4'd4, st);
        check("R10", 64'(st[12]), 64'd0);
        wr(4'd0, 32'd0); wr(4'd1, 32'd31); wr(4'd2, 32'd1);
        wr(4'd3, 32'h5);
        rd(4'd4, st);
        check("R10", 64'({st[12], st[0]}), 64'b10);
        repeat (8) @(negedge clk);
        check("R10", 64'(acks - a0), 64'd0);
        wr(4'd5, 32'd0);
        run_job("R10", 29, 29, 2, 1'b0, 1'b0, 1'b0);
        rd(4'd4, st);
        check("R10", 64'(st[12]), 64'd0);

        // zero fill
        wr(4'd6, 32'h2);
        wipe_phase = 1'b1;
        wr(4'd6, 32'h4);
        rd(4'd4, st);
        check("R12", 64'({st[2], st[1], st[0]}), 64'b011);
        wait_idle(st);
        wipe_phase = 1'b0;
        check("R12", 64'({st[10], st[8], st[0]}), 64'd0);
        check("R12", 64'(irq), 64'd0);
        bad = 0;
        for (int i = 0; i < DEPTH; i++) if (pt_mem[i] !== '0 || ct_mem[i] !== '0) bad++;
        check("R12", 64'(bad), 64'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule